// File: doc/BRIEF.md
# Counter Access and Enable CSR Unit

This unit holds one 64-bit event counter, used for both the cycle and the retired-instruction views, and the two per-counter permission registers that decide whether code running below machine level may read it. A core's CSR stage presents an address, read and write strobes, write data, the current privilege level and a flag for 32-bit operation. In the same cycle the unit returns either read data or an illegal-access indication. The counter advances by one on every cycle in which the retire pulse is high.

Lower-privilege reads pass through a chain of permission masks. The machine-level enable register filters supervisor and user code. The supervisor-level enable register filters user code as well. The bit tested is selected by the low five address bits. When the core runs with 32-bit registers, each half of the counter has its own address for reads and writes. Performance counters and event selectors that are not implemented read as zero.

Top module: `ctr_csr_unit`

## Requirements
- R1: Reset clears the counter. Each clock edge with `retire` high and no counter write adds one, wrapping modulo 2^64; in 32-bit mode a carry out of the low half reaches the high half.
- R2: A legal counter write in the same cycle as `retire` loads the written value, and no increment is applied.
- R3: Privilege is encoded 3 = machine, 1 = supervisor, 0 = user. The access mask starts as all ones. Below machine it is ANDed with the machine enable register. At user level it is also ANDed with the supervisor enable register. Bit `addr[4:0]` of the mask permits a read at 0xC00+n, or at 0xC80+n in 32-bit mode; if that bit is clear the access is illegal.
- R4: When permitted, 0xC00 and 0xC02 return the same shared counter, and 0xC03 to 0xC1F return zero. Any write to a 0xC.. address is illegal.
- R5: 0xB00 and 0xB02 read the counter and accept writes at any privilege, with either enable register set to any value.
- R6: 0xB03 to 0xB1F and 0x323 to 0x33F are legal, read zero, and ignore writes. In 32-bit mode, 0xB83 to 0xB9F and 0xC83 to 0xC9F behave the same way, the latter still subject to R3.
- R7: In 32-bit mode, counter reads return one half, zero-extended: bits 31:0 at 0x?00/0x?02 and bits 63:32 at 0x?80/0x?82.
- R8: In 32-bit mode, a write to 0xB00/0xB02 replaces bits 31:0 and keeps bits 63:32. A write to 0xB80/0xB82 replaces bits 63:32 and keeps bits 31:0.
- R9: In 64-bit mode, a write to 0xB00/0xB02 replaces all 64 bits, and reads return all 64 bits. Any access to a high-half address (0xB80..0xB9F, 0xC80..0xC9F) is illegal.
- R10: The machine enable register (0x306) and the supervisor enable register (0x106) are 32-bit read/write registers that reset to zero. They read back zero-extended.
- R11: Any other address (including 0xB01, 0xC01, 0x320 to 0x322) is illegal. An illegal access returns zero data and changes no state. `csr_illegal` is low when neither strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_addr | input | 12 | CSR address |
| csr_rd | input | 1 | Read strobe |
| csr_wr | input | 1 | Write strobe |
| csr_wdata | input | 64 | Write data |
| priv | input | 2 | Current privilege (3 machine, 1 supervisor, 0 user) |
| mode32 | input | 1 | 32-bit register mode |
| retire | input | 1 | Increment pulse |
| csr_rdata | output | 64 | Read data, zero unless a legal read |
| csr_illegal | output | 1 | Access is not permitted or not decoded |

## Verification
The assertions cover several behaviours on every cycle:
- increment and hold of the counter;
- priority of a write over a simultaneous increment;
- preservation of the untouched half on a 32-bit low-half write;
- zero data on an illegal access;
- rejection of high-half addresses in 64-bit mode;
- legality of machine counter reads and of the event-selector range.

The permission chain depends on both enable registers together with privilege and address. Only the bench's sweeps over every counter index, several enable patterns and all three privilege levels show it, and they also cover half selection in 32-bit mode, carry between halves and wrap at all ones.

// File: rtl/ctr_csr_unit.sv
module ctr_csr_unit #(
  parameter int HALF_W = 32,
  parameter int NCTR   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [11:0]       csr_addr,
  input  logic              csr_rd,
  input  logic              csr_wr,
  input  logic [2*HALF_W-1:0] csr_wdata,
  input  logic [1:0]        priv,
  input  logic              mode32,
  input  logic              retire,
  output logic [2*HALF_W-1:0] csr_rdata,
  output logic              csr_illegal
);
  localparam int CTR_W = 2 * HALF_W;
  localparam int IDX_W = $clog2(NCTR);
  localparam logic [1:0] PRIV_M = 2'd3;
  localparam logic [1:0] PRIV_U = 2'd0;

  logic [CTR_W-1:0] ctr;
  logic [NCTR-1:0]  m_en, s_en, amask;
  logic [CTR_W-1:0] view, rval;

  wire [IDX_W-1:0] idx = csr_addr[IDX_W-1:0];
  wire hi      = csr_addr[7];
  wire grp_ok  = csr_addr[6:5] == 2'b00;
  wire is_user = csr_addr[11:8] == 4'hC && grp_ok;
  wire is_mach = csr_addr[11:8] == 4'hB && grp_ok;
  wire is_evt  = csr_addr[11:5] == 7'h19;
  wire is_men  = csr_addr == 12'h306;
  wire is_sen  = csr_addr == 12'h106;
  wire base    = idx == 0 || idx == 2;
  wire hpm     = idx >= 3;
  wire half_ok = !hi || mode32;

  always_comb begin
    amask = '1;
    if (priv != PRIV_M) amask = amask & m_en;
    if (priv == PRIV_U) amask = amask & s_en;
  end

  wire u_leg = is_user && half_ok && (base || hpm) && amask[idx] && !csr_wr;
  wire m_leg = is_mach && half_ok && (base || hpm);
  wire e_leg = is_evt && hpm;
  wire legal = u_leg || m_leg || e_leg || is_men || is_sen;
  wire ctr_wr = csr_wr && m_leg && base;

  always_comb begin
    if (!mode32)  view = ctr;
    else if (hi)  view = {{HALF_W{1'b0}}, ctr[CTR_W-1:HALF_W]};
    else          view = {{HALF_W{1'b0}}, ctr[HALF_W-1:0]};
  end

  always_comb begin
    rval = '0;
    if ((u_leg || m_leg) && base) rval = view;
    else if (is_men)              rval = CTR_W'(m_en);
    else if (is_sen)              rval = CTR_W'(s_en);
  end

  assign csr_rdata   = (csr_rd && legal) ? rval : '0;
  assign csr_illegal = (csr_rd || csr_wr) && !legal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctr  <= '0;
      m_en <= '0;
      s_en <= '0;
    end else begin
      if (ctr_wr) begin
        if (!mode32)  ctr <= csr_wdata;
        else if (hi)  ctr[CTR_W-1:HALF_W] <= csr_wdata[HALF_W-1:0];
        else          ctr[HALF_W-1:0]     <= csr_wdata[HALF_W-1:0];
      end else if (retire) begin
        ctr <= ctr + 1'b1;
      end
      if (csr_wr && is_men) m_en <= csr_wdata[NCTR-1:0];
      if (csr_wr && is_sen) s_en <= csr_wdata[NCTR-1:0];
    end
  end
endmodule

// File: rtl/ctr_csr_unit_chk.sv
module ctr_csr_unit_chk #(
  parameter int CTR_W  = 64,
  parameter int HALF_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [11:0]      csr_addr,
  input logic             csr_rd,
  input logic             csr_wr,
  input logic [CTR_W-1:0] csr_wdata,
  input logic             mode32,
  input logic             retire,
  input logic [CTR_W-1:0] csr_rdata,
  input logic             csr_illegal,
  input logic [CTR_W-1:0] ctr
);
  wire cwr = csr_wr && !csr_illegal && csr_addr[11:8] == 4'hB &&
             csr_addr[6:5] == 2'b00 && (csr_addr[4:0] == 5'd0 || csr_addr[4:0] == 5'd2);
  wire hi_addr = (csr_addr[11:8] == 4'hB || csr_addr[11:8] == 4'hC) && csr_addr[7:5] == 3'b100;

  p_inc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && !cwr) |=> ctr == $past(ctr) + 1'b1);
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!retire && !cwr) |=> $stable(ctr));
  p_wr_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cwr && !mode32) |=> ctr == $past(csr_wdata));
  p_low_keeps_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cwr && mode32 && !csr_addr[7]) |=> ctr[CTR_W-1:HALF_W] == $past(ctr[CTR_W-1:HALF_W]));
  p_hi64_illegal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((csr_rd || csr_wr) && !mode32 && hi_addr) |-> csr_illegal);
  p_mach_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rd && csr_addr == 12'hB00) |-> !csr_illegal);
  p_evt_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rd && csr_addr == 12'h323) |-> (!csr_illegal && csr_rdata == '0));
  p_illegal_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal |-> csr_rdata == '0);
endmodule

bind ctr_csr_unit ctr_csr_unit_chk #(.CTR_W(2*HALF_W), .HALF_W(HALF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_rd(csr_rd), .csr_wr(csr_wr),
  .csr_wdata(csr_wdata), .mode32(mode32), .retire(retire), .csr_rdata(csr_rdata),
  .csr_illegal(csr_illegal), .ctr(ctr));

// File: tb/ctr_csr_unit_test.sv
`timescale 1ns/1ps
module ctr_csr_unit_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [11:0] csr_addr = '0;
  logic        csr_rd = 0, csr_wr = 0;
  logic [63:0] csr_wdata = '0;
  logic [1:0]  priv = 2'd3;
  logic        mode32 = 0;
  logic        retire = 0;
  logic [63:0] csr_rdata;
  logic        csr_illegal;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [63:0] model;
  logic        g_ill;
  logic [63:0] g_dat;

  always #10 clk = ~clk;

  ctr_csr_unit uut (.clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_rd(csr_rd),
    .csr_wr(csr_wr), .csr_wdata(csr_wdata), .priv(priv), .mode32(mode32),
    .retire(retire), .csr_rdata(csr_rdata), .csr_illegal(csr_illegal));

  task automatic op(input logic [11:0] a, input logic r, input logic w,
                    input logic [63:0] d, input logic ret);
    @(negedge clk);
    csr_addr = a; csr_rd = r; csr_wr = w; csr_wdata = d; retire = ret;
    #1 g_ill = csr_illegal; g_dat = csr_rdata;
    @(posedge clk);
    #1 csr_rd = 0; csr_wr = 0; retire = 0;
  endtask

  task automatic chk(input string tag, input logic [64:0] got, input logic [64:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic ill, input logic [63:0] d);
    op(a, 1, 0, '0, 0);
    chk(tag, {g_ill, g_dat}, {ill, d});
  endtask

  task automatic pulses(input int n);
    @(negedge clk); retire = 1;
    repeat (n) @(posedge clk);
    #1 retire = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    model = '0;

    rd_chk("R1 reset counter", 12'hB00, 0, 64'd0);
    rd_chk("R10 reset men", 12'h306, 0, 64'd0);
    rd_chk("R10 reset sen", 12'h106, 0, 64'd0);
    op(12'h000, 0, 0, '0, 0);
    chk("R11 idle no illegal", {64'd0, g_ill}, 65'd0);

    model = 64'h1234_5678_9ABC_DEF0;
    op(12'hB00, 0, 1, model, 0);
    rd_chk("R9 full write", 12'hB02, 0, model);

    for (int pat = 0; pat < 3; pat++) begin
      logic [31:0] me, se;
      me = (pat == 0) ? 32'hFFFF_FFFF : (pat == 1) ? 32'h0000_0005 : 32'hA5A5_5A5A;
      se = (pat == 0) ? 32'h0000_0000 : (pat == 1) ? 32'hFFFF_FFFF : 32'h3C3C_C3C3;
      op(12'h306, 0, 1, {32'h0, me}, 0);
      op(12'h106, 0, 1, {32'h0, se}, 0);
      rd_chk("R10 men readback", 12'h306, 0, {32'h0, me});
      rd_chk("R10 sen readback", 12'h106, 0, {32'h0, se});
      for (int p = 0; p < 3; p++) begin
        logic [31:0] m;
        priv = (p == 0) ? 2'd0 : (p == 1) ? 2'd1 : 2'd3;
        m = '1;
        if (priv != 2'd3) m = m & me;
        if (priv == 2'd0) m = m & se;
        for (int i = 0; i < 32; i++) begin
          logic ok;
          ok = (i != 1) && m[i];
          rd_chk("R3 R4 user read", 12'hC00 + 12'(i), !ok,
                 (ok && (i == 0 || i == 2)) ? model : 64'd0);
        end
        rd_chk("R5 machine read", 12'hB00, 0, model);
      end
    end

    priv = 2'd0;
    op(12'h306, 0, 1, '0, 0);
    for (int i = 0; i < 32; i++)
      rd_chk("R5 R6 machine sweep", 12'hB00 + 12'(i), i == 1,
             (i == 0 || i == 2) ? model : 64'd0);
    for (int i = 0; i < 32; i++)
      rd_chk("R6 R11 event sweep", 12'h320 + 12'(i), i < 3, 64'd0);
    op(12'hB05, 0, 1, 64'hFFFF, 0);
    chk("R6 write ignored legal", {64'd0, g_ill}, 65'd0);
    rd_chk("R6 counter after ignored write", 12'hB00, 0, model);
    priv = 2'd3;

    pulses(37);
    model = model + 64'd37;
    rd_chk("R1 increments", 12'hB02, 0, model);
    rd_chk("R4 shared alias", 12'hC00, 0, model);
    rd_chk("R4 shared alias instret", 12'hC02, 0, model);

    model = 64'hCAFE_0000_0000_0042;
    op(12'hB00, 0, 1, model, 1);
    rd_chk("R2 write beats retire", 12'hB00, 0, model);

    model = '1;
    op(12'hB02, 0, 1, model, 0);
    pulses(1);
    model = '0;
    rd_chk("R1 wrap", 12'hB00, 0, 64'd0);

    mode32 = 1;
    op(12'hB80, 0, 1, 64'hFFFF_FFFF_0000_0005, 0);
    op(12'hB00, 0, 1, 64'h1111_1111_FFFF_FFFF, 0);
    rd_chk("R7 R8 low half", 12'hB00, 0, 64'h0000_0000_FFFF_FFFF);
    rd_chk("R7 R8 high half", 12'hB80, 0, 64'h0000_0000_0000_0005);
    pulses(1);
    rd_chk("R1 carry low", 12'hB02, 0, 64'd0);
    rd_chk("R1 carry high", 12'hB82, 0, 64'd6);
    op(12'hB02, 0, 1, 64'h0000_0000_ABCD_0001, 0);
    rd_chk("R8 high kept", 12'hB80, 0, 64'd6);
    rd_chk("R7 user high", 12'hC80, 0, 64'd6);
    for (int i = 0; i < 32; i++)
      rd_chk("R6 R7 high sweep", 12'hB80 + 12'(i), i == 1,
             (i == 0 || i == 2) ? ((i == 0) ? 64'd6 : 64'd6) : 64'd0);
    mode32 = 0;
    model = 64'h0000_0006_ABCD_0001;
    rd_chk("R9 full read", 12'hB00, 0, model);

    rd_chk("R9 high illegal 64", 12'hB80, 1, 64'd0);
    rd_chk("R9 user high illegal 64", 12'hC82, 1, 64'd0);
    op(12'hB80, 0, 1, 64'hFFFF, 0);
    chk("R9 high write illegal", {64'd0, g_ill}, {64'd0, 1'b1});
    rd_chk("R9 no change", 12'hB00, 0, model);
    op(12'hC00, 0, 1, 64'h5, 0);
    chk("R4 R11 user write illegal", {64'd0, g_ill}, {64'd0, 1'b1});
    rd_chk("R11 no change", 12'hB00, 0, model);
    rd_chk("R11 unknown", 12'h7FF, 1, 64'd0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog got timeout exp completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule